// File: doc/BRIEF.md
# Dithered Ring-Oscillator Coarse Interval Decoder

This block is the digital back end of a start-stop time-to-digital converter built around a four-stage ring oscillator. Each stage is nominally 50 ps, so one phase step of the oscillator is one 50 ps quantum. Eight such steps make one full oscillator period. Before every conversion the block draws a pseudo-random starting phase and loads it into the oscillator as a preset. A START pulse enables the oscillator, and the block counts full periods while it runs. A STOP pulse is synchronised into the clock domain and ends the run. The block then decodes the sampled stage outputs into a 3-bit phase and joins that phase to the period count. Finally it subtracts the starting phase, which gives the binary interval.

Starting each conversion from a different phase spreads the mismatch between the delay stages across all codes, which improves linearity. The price is that the decoder has to remove the preset from every result. The period counter width is a parameter, and each extra bit doubles the range. A run that never sees a STOP ends with a saturated code and an overflow flag. A sampled stage pattern that cannot occur in a healthy oscillator raises an error flag.

Top module: `coarse_tdc_decoder`

## Requirements
- R1: While synchronous reset is high, and after it is released, `ring_en_o`, `ring_load_o`, `valid_o`, `overflow_o` and `code_err_o` are low.
- R2: A `start_i` pulse seen in the idle state causes exactly one cycle of `ring_load_o`, with `ring_en_o` low, while `ring_preset_o` carries the start phase. `ring_en_o` is high in the next cycle and stays high until the run ends.
- R3: The start phase is bits [2:0] of a 16-bit LFSR. The LFSR shifts left, and its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. It steps once per preset. Its reset value is 0xACE1. `seed_load_i` loads `seed_i`, and a zero seed is loaded as 0x0001.
- R4: While `lfsr_freeze_i` is high the LFSR does not step, so consecutive conversions use the same start phase.
- R5: Phase p is encoded on the stage outputs with bit i = stage i. For p = 0 to 4 the low p bits are one and the rest are zero. For p = 5 to 7 the low p-4 bits are zero and the rest are one. Each falling edge of stage 3 counts one period. The result is {count, phase} minus the start phase, modulo 2^(CNT_W+3). It equals the number of phase steps the oscillator took while enabled.
- R6: `stop_i` passes through SYNC_STAGES flip-flops, and its synchronised rising edge ends the run. `valid_o` then pulses high for exactly one cycle together with the result.
- R7: A STOP outside a running conversion is ignored: it enables nothing and produces no `valid_o`.
- R8: If the start phase plus the steps taken reaches 2^(CNT_W+3), the result is all ones, with `overflow_o` high and `valid_o` high. Otherwise `overflow_o` is low.
- R9: A captured stage pattern that is none of the eight phase patterns raises `code_err_o` with `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START trigger, synchronous pulse |
| stop_i | input | 1 | STOP trigger, asynchronous pulse |
| seed_load_i | input | 1 | Load `seed_i` into the LFSR |
| seed_i | input | 16 | LFSR seed value |
| lfsr_freeze_i | input | 1 | Hold the LFSR (test) |
| ring_stage_i | input | 4 | Sampled oscillator stage outputs |
| ring_load_o | output | 1 | Load preset into oscillator |
| ring_preset_o | output | 3 | Preset start phase |
| ring_en_o | output | 1 | Oscillator enable |
| result_o | output | CNT_W+3 | Interval code in phase steps |
| valid_o | output | 1 | One-cycle result strobe |
| overflow_o | output | 1 | Range exceeded |
| code_err_o | output | 1 | Invalid sampled stage pattern |

## Verification
Overflow is the hardest case to reach from the ports. It occurs only when the random start phase and the steps taken together reach the full range, and it can happen either mid-run or on the very cycle of capture. The stimulus gets there by omitting STOP entirely, so the run always crosses the limit. The bench judges every result against the start phase it observed on `ring_preset_o`. A corrupted stage pattern is shown only after the oscillator is disabled, which reaches the error path without disturbing period counting.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int PH_W     = 3;
    localparam int NUM_STG  = 4;
    localparam int NUM_PH   = 1 << PH_W;
    localparam int LFSR_W   = 16;
    localparam logic [LFSR_W-1:0] LFSR_RST = 16'hACE1;

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESET,
        ST_RUN,
        ST_CAPTURE,
        ST_DONE
    } meas_state_e;

    typedef struct packed {
        logic   ok;
        phase_t code;
    } phase_dec_t;

    // Stage pattern produced by the ring in phase p (bit i = stage i).
    function automatic logic [NUM_STG-1:0] phase_pattern(phase_t p);
        logic [NUM_STG-1:0] r;
        if (p[2]) r = 4'hF << p[1:0];
        else      r = 4'((5'd1 << p[1:0]) - 5'd1);
        return r;
    endfunction

    function automatic phase_dec_t decode_phase(logic [NUM_STG-1:0] s);
        phase_dec_t r;
        r = '0;
        for (int i = 0; i < NUM_PH; i++) begin
            if (phase_pattern(phase_t'(i)) == s) begin
                r.ok   = 1'b1;
                r.code = phase_t'(i);
            end
        end
        return r;
    endfunction

    // Polynomial x^16 + x^14 + x^13 + x^11 + 1, left-shifting form.
    function automatic logic [LFSR_W-1:0] lfsr_next(logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction
endpackage

// File: rtl/tdc_lfsr.sv
module tdc_lfsr
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              step_i,
    input  logic              freeze_i,
    output phase_t            phase_o
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)                      state_q <= LFSR_RST;
        else if (load_i)              state_q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
        else if (step_i && !freeze_i) state_q <= lfsr_next(state_q);
    end

    assign phase_o = state_q[PH_W-1:0];

    // R3: the all-zero lock-up state is never entered
    a_r3_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R4: frozen register holds its value
    a_r4_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LEN-2:0], async_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R6: a single STOP edge yields a single-cycle event
    a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tdc_phase_decode.sv
module tdc_phase_decode
    import tdc_pkg::*;
(
    input  logic [NUM_STG-1:0] stage_i,
    output phase_dec_t         dec_o
);
    always_comb dec_o = decode_phase(stage_i);
endmodule

// File: rtl/coarse_tdc_decoder.sv
module coarse_tdc_decoder
    import tdc_pkg::*;
#(
    parameter int CNT_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic                   seed_load_i,
    input  logic [15:0]            seed_i,
    input  logic                   lfsr_freeze_i,
    input  logic [3:0]             ring_stage_i,
    output logic                   ring_load_o,
    output logic [2:0]             ring_preset_o,
    output logic                   ring_en_o,
    output logic [CNT_W+2:0]       result_o,
    output logic                   valid_o,
    output logic                   overflow_o,
    output logic                   code_err_o
);
    localparam int RES_W = CNT_W + PH_W;

    meas_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    phase_t           start_ph_q;
    phase_t           lfsr_ph;
    logic             s3_q;
    logic             stop_rise;
    phase_dec_t       dec;
    logic             wrap_now, ovf_now;
    logic [RES_W-1:0] total, interval;

    tdc_lfsr u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (seed_load_i),
        .seed_i   (seed_i),
        .step_i   (state_q == ST_PRESET),
        .freeze_i (lfsr_freeze_i),
        .phase_o  (lfsr_ph)
    );

    tdc_edge_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (stop_i),
        .rise_o  (stop_rise)
    );

    tdc_phase_decode u_dec (
        .stage_i (ring_stage_i),
        .dec_o   (dec)
    );

    // A falling edge on the last stage marks a completed period.
    assign wrap_now = s3_q & ~ring_stage_i[NUM_STG-1];
    assign ovf_now  = wrap_now & (&cnt_q);
    assign total    = {cnt_q + CNT_W'(wrap_now), dec.code};
    assign interval = total - RES_W'(start_ph_q);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_PRESET;
            ST_PRESET:  state_d = ST_RUN;
            ST_RUN: begin
                if (ovf_now)        state_d = ST_DONE;
                else if (stop_rise) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            start_ph_q <= '0;
            s3_q       <= 1'b0;
            result_o   <= '0;
            valid_o    <= 1'b0;
            overflow_o <= 1'b0;
            code_err_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            valid_o    <= 1'b0;
            overflow_o <= 1'b0;
            code_err_o <= 1'b0;
            if (state_q == ST_PRESET) begin
                cnt_q      <= '0;
                start_ph_q <= lfsr_ph;
                s3_q       <= lfsr_ph[PH_W-1];
            end else begin
                s3_q <= ring_stage_i[NUM_STG-1];
            end
            if (state_q == ST_RUN && wrap_now)
                cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_RUN && ovf_now) begin
                valid_o    <= 1'b1;
                overflow_o <= 1'b1;
                result_o   <= '1;
            end
            if (state_q == ST_CAPTURE) begin
                valid_o <= 1'b1;
                if (!dec.ok) begin
                    code_err_o <= 1'b1;
                    result_o   <= '0;
                end else if (ovf_now) begin
                    overflow_o <= 1'b1;
                    result_o   <= '1;
                end else begin
                    result_o <= interval;
                end
            end
        end
    end

    assign ring_load_o   = (state_q == ST_PRESET);
    assign ring_en_o     = (state_q == ST_RUN);
    assign ring_preset_o = lfsr_ph;

    // R2: preset cycle is followed by an enabled oscillator
    a_r2_load_then_run: assert property (@(posedge clk) disable iff (rst)
        ring_load_o |=> ring_en_o);
    // R2: preset and enable never overlap
    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ring_load_o && ring_en_o));
    // R6: result strobe lasts one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R7: idle never enables the oscillator directly
    a_r7_idle_no_enable: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !ring_en_o);
    // R8: overflow reports saturated code with the strobe
    a_r8_ovf_all_ones: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (valid_o && (&result_o)));
    // R9: error flag only accompanies a strobe and excludes overflow
    a_r9_err_with_valid: assert property (@(posedge clk) disable iff (rst)
        code_err_o |-> (valid_o && !overflow_o));
endmodule

// File: tb/coarse_tdc_decoder_tb_top.sv
module coarse_tdc_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 2;
    localparam int RES_W      = CNT_W + 3;
    localparam int RANGE      = 1 << RES_W;
    localparam int WD_LIMIT   = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0, stop_i = 1'b0;
    logic             seed_load_i = 1'b0, lfsr_freeze_i = 1'b0;
    logic [15:0]      seed_i = '0;
    logic [3:0]       ring_stage_i;
    logic             ring_load_o, ring_en_o, valid_o, overflow_o, code_err_o;
    logic [2:0]       ring_preset_o;
    logic [RES_W-1:0] result_o;

    coarse_tdc_decoder #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .seed_load_i(seed_load_i), .seed_i(seed_i), .lfsr_freeze_i(lfsr_freeze_i),
        .ring_stage_i(ring_stage_i), .ring_load_o(ring_load_o),
        .ring_preset_o(ring_preset_o), .ring_en_o(ring_en_o), .result_o(result_o),
        .valid_o(valid_o), .overflow_o(overflow_o), .code_err_o(code_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Oscillator model
    logic [2:0] osc_ph = '0;
    logic [2:0] seen_preset = '0;
    int         steps = 0;
    bit         corrupt = 1'b0;

    function automatic logic [3:0] ring_pattern(logic [2:0] p);
        case (p)
            3'd0: return 4'b0000;
            3'd1: return 4'b0001;
            3'd2: return 4'b0011;
            3'd3: return 4'b0111;
            3'd4: return 4'b1111;
            3'd5: return 4'b1110;
            3'd6: return 4'b1100;
            default: return 4'b1000;
        endcase
    endfunction

    assign ring_stage_i = (corrupt && !ring_en_o) ? 4'b0101 : ring_pattern(osc_ph);

    always @(posedge clk) begin
        if (ring_load_o) begin
            osc_ph      <= ring_preset_o;
            seen_preset <= ring_preset_o;
            steps       <= 0;
        end else if (ring_en_o) begin
            osc_ph <= osc_ph + 3'd1;
            steps  <= steps + 1;
        end
    end

    // Start-phase model (R3, R4)
    logic [15:0] model_lfsr = '0;
    bit          model_on = 1'b0;
    bit          prev_load = 1'b0;

    function automatic logic [15:0] model_next(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_load) check("R2", "enable after preset", int'(ring_en_o), 1);
            if (ring_load_o) begin
                check("R2", "enable low during preset", int'(ring_en_o), 0);
                if (model_on) begin
                    if (lfsr_freeze_i)
                        check("R4", "frozen start phase", int'(ring_preset_o), int'(model_lfsr[2:0]));
                    else begin
                        check("R3", "start phase", int'(ring_preset_o), int'(model_lfsr[2:0]));
                        model_lfsr = model_next(model_lfsr);
                    end
                end
            end
            prev_load = ring_load_o;
        end
    end

    // Scoreboard: each item is "corrupt capture expected"
    bit exp_q[$];
    bit prev_valid = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                check("R6", "strobe width", int'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    check("R7", "unexpected result strobe", 1, 0);
                end else begin
                    bit c;
                    bit ovf_exp;
                    c = exp_q.pop_front();
                    ovf_exp = (int'(seen_preset) + steps) >= RANGE;
                    if (c) begin
                        check("R9", "code error flag", int'(code_err_o), 1);
                    end else if (ovf_exp) begin
                        check("R8", "overflow flag", int'(overflow_o), 1);
                        check("R8", "saturated code", int'(result_o), RANGE - 1);
                    end else begin
                        check("R5", "interval code", int'(result_o), steps);
                        check("R8", "no overflow", int'(overflow_o), 0);
                        check("R9", "no code error", int'(code_err_o), 0);
                    end
                end
            end
            prev_valid = valid_o;
        end
    end

    task automatic load_seed(logic [15:0] s);
        @(negedge clk);
        seed_i      = s;
        seed_load_i = 1'b1;
        model_lfsr  = (s == 16'h0) ? 16'h0001 : s;
        model_on    = 1'b1;
        @(negedge clk);
        seed_load_i = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!valid_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) check("R6", "result strobe timeout", 0, 1);
    endtask

    task automatic measure(int run_cycles, bit corr, bit send_stop);
        exp_q.push_back(corr);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (run_cycles) @(negedge clk);
        if (send_stop) begin
            corrupt = corr;
            stop_i  = 1'b1;
            @(negedge clk);
            stop_i  = 1'b0;
        end
        wait_valid();
        @(negedge clk);
        corrupt = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
        finish_run();
    end

    initial begin
        bit bad;
        repeat (3) @(negedge clk);
        check("R1", "enable in reset", int'(ring_en_o), 0);
        check("R1", "load in reset", int'(ring_load_o), 0);
        check("R1", "strobe in reset", int'(valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "flags after reset", int'({overflow_o, code_err_o, valid_o, ring_en_o}), 0);

        load_seed(16'h1D2B);
        measure(2, 1'b0, 1'b1);
        measure(9, 1'b0, 1'b1);
        measure(15, 1'b0, 1'b1);
        measure(0, 1'b0, 1'b1);
        measure(7, 1'b0, 1'b1);

        // R7: STOP while idle
        bad = 1'b0;
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (ring_en_o || valid_o) bad = 1'b1;
        end
        check("R7", "stop in idle ignored", int'(bad), 0);
        measure(5, 1'b0, 1'b1);

        // R4: frozen start phase
        @(negedge clk); lfsr_freeze_i = 1'b1;
        measure(5, 1'b0, 1'b1);
        measure(11, 1'b0, 1'b1);
        @(negedge clk); lfsr_freeze_i = 1'b0;

        // R3: zero seed substitution
        load_seed(16'h0000);
        measure(4, 1'b0, 1'b1);
        measure(8, 1'b0, 1'b1);

        // R9: corrupted capture
        measure(3, 1'b1, 1'b1);

        // R8: no STOP, run to saturation
        measure(0, 1'b0, 1'b0);
        measure(12, 1'b0, 1'b1);

        repeat (5) @(negedge clk);
        check("R6", "all expected results produced", exp_q.size(), 0);
        finish_run();
    end
endmodule